// File: doc/BRIEF.md
# Capture Crop, Halve and Frame-Skip Stage

This block sits in a pixel capture path between the sensor-side receiver and the downstream writer. It takes a raw pixel stream qualified by a frame-valid level, a line-valid level and a per-cycle pixel-valid strobe. It keeps a rectangular window of each frame and can optionally halve that window along either axis. It also lowers the frame rate by dropping whole frames according to a repeating pattern. The kept pixels leave as a stream with freshly generated start-of-frame and end-of-line markers and a line-valid level.

Pixels are counted from zero along each line, and lines are counted from zero within each frame. The window is set by an x/y offset and a width/height, and it is applied before any halving. Halving keeps every second pixel or line, counted from the window origin. All settings are copied into shadow registers on the rising edge of frame-valid, so changing them while a frame is running never splits that frame. A window that runs past the edge of the incoming frame is cut off at that edge, and a sticky flag records the event.

Top module: `cap_window_decim`

## Requirements
- R1: An output pixel is exactly an input pixel whose column x and row y satisfy x_off <= x < x_off+width and y_off <= y < y_off+height. Pixels leave in input order and the pixel data is unchanged.
- R2: With halve_h set, only columns where (x - x_off) is even are kept. This choice does not depend on the vertical setting.
- R3: With halve_v set, only rows where (y - y_off) is even are kept. This choice does not depend on the horizontal setting.
- R4: Each output frame has exactly the size of the cropped and halved rectangle, with ceil(width/2) columns and ceil(height/2) rows when halving is on. For example, a 32x24 window of a 64x48 frame, halved on both axes, gives 16x12. With halving off, the output size is the window size.
- R5: A frame phase counter starts at 0 for the first frame after reset and advances by one per frame. It wraps at the skip period, and a period of 0 counts as 1. A frame whose phase k is below 5 with mask bit k set is dropped whole. Mask 5'b00001 with period 2 passes every second frame (phases 1), halving the frame rate.
- R6: The window, halving and skip settings are sampled on the rising edge of frame-valid. A change made while a frame is in progress first affects the next frame.
- R7: out_sof is high on the first output pixel of each passed frame. out_eol is high on the last output pixel of each output line. Both are only ever high together with out_valid. out_lv is high from the first pixel to the end-of-line pixel of each output line and low between output lines.
- R8: A window that extends past the last column or last row of the input frame is clipped to the input edge. In that case clip_err rises and stays high until reset. A window that lies inside the frame leaves clip_err low.
- R9: While reset is high and on the cycle after it, out_valid, out_sof, out_eol, out_lv and clip_err are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_fv | input | 1 | Input frame-valid level |
| in_lv | input | 1 | Input line-valid level |
| in_pv | input | 1 | Input pixel-valid strobe, qualified by in_lv |
| in_pix | input | PIX_W | Input pixel data |
| cfg_x_off | input | DIM_W | Window first column |
| cfg_y_off | input | DIM_W | Window first row |
| cfg_width | input | DIM_W | Window width in pixels |
| cfg_height | input | DIM_W | Window height in lines |
| cfg_halve_h | input | 1 | Keep every second column of the window |
| cfg_halve_v | input | 1 | Keep every second row of the window |
| cfg_skip_mask | input | 5 | Bit k drops frame phase k |
| cfg_skip_period | input | 5 | Frame phase period (0 counts as 1) |
| out_valid | output | 1 | Output pixel valid |
| out_pix | output | PIX_W | Output pixel data |
| out_sof | output | 1 | First pixel of an output frame |
| out_eol | output | 1 | Last pixel of an output line |
| out_lv | output | 1 | Output line-valid level |
| clip_err | output | 1 | Sticky window-clipped flag |

## Verification
The assertions assume a well-formed raster on the inputs. Frame-valid must rise at least one cycle before the first line-valid. Line-valid must fall at least one cycle before frame-valid falls. Pixel-valid has meaning only under line-valid, and line and frame lengths must stay below 2^DIM_W. The stimulus tasks meet these conditions by holding frame-valid for two cycles before the first line and for two cycles after the last one. They also leave three idle cycles between lines and drive every input on the falling clock edge. In one scenario the stimulus inserts pixel-valid gaps inside lines, to show that positions are counted per valid pixel and not per cycle.

// File: rtl/cwd_pkg.sv
package cwd_pkg;

    localparam int SKIP_W = 5;

    typedef logic [SKIP_W-1:0] skip_t;

    typedef struct packed {
        logic sof;
        logic eol;
    } mark_t;

    // A zero period behaves as a period of one frame.
    function automatic skip_t eff_period(skip_t period);
        return (period == '0) ? skip_t'(1) : period;
    endfunction

    // Fold a phase left over from a longer period back to zero.
    function automatic skip_t wrap_phase(skip_t ph, skip_t period);
        return (ph >= eff_period(period)) ? '0 : ph;
    endfunction

    function automatic skip_t step_phase(skip_t ph, skip_t period);
        skip_t nxt;
        nxt = ph + skip_t'(1);
        return (nxt >= eff_period(period)) ? '0 : nxt;
    endfunction

    // Phases beyond the mask width never drop.
    function automatic logic drop_at(skip_t mask, skip_t ph);
        skip_t sh;
        sh = mask >> ph;
        return sh[0];
    endfunction

endpackage

// File: rtl/cwd_cfg_latch.sv
module cwd_cfg_latch
    import cwd_pkg::*;
#(
    parameter int DIM_W = 12
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             frame_start,
    input  logic [DIM_W-1:0] cfg_x_off,
    input  logic [DIM_W-1:0] cfg_y_off,
    input  logic [DIM_W-1:0] cfg_width,
    input  logic [DIM_W-1:0] cfg_height,
    input  logic             cfg_halve_h,
    input  logic             cfg_halve_v,
    input  skip_t            cfg_skip_mask,
    input  skip_t            cfg_skip_period,
    output logic [DIM_W-1:0] x_off,
    output logic [DIM_W-1:0] y_off,
    output logic [DIM_W-1:0] width,
    output logic [DIM_W-1:0] height,
    output logic             halve_h,
    output logic             halve_v,
    output logic             drop_frame
);

    skip_t phase_q;
    skip_t phase_now;

    assign phase_now = wrap_phase(phase_q, cfg_skip_period);

    always_ff @(posedge clk) begin
        if (rst) begin
            x_off      <= '0;
            y_off      <= '0;
            width      <= '0;
            height     <= '0;
            halve_h    <= 1'b0;
            halve_v    <= 1'b0;
            drop_frame <= 1'b0;
            phase_q    <= '0;
        end else if (frame_start) begin
            x_off      <= cfg_x_off;
            y_off      <= cfg_y_off;
            width      <= cfg_width;
            height     <= cfg_height;
            halve_h    <= cfg_halve_h;
            halve_v    <= cfg_halve_v;
            drop_frame <= drop_at(cfg_skip_mask, phase_now);
            phase_q    <= step_phase(phase_now, cfg_skip_period);
        end
    end

endmodule

// File: rtl/cwd_raster.sv
module cwd_raster #(
    parameter int DIM_W = 12
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_fv,
    input  logic             in_lv,
    input  logic             in_pv,
    input  logic [DIM_W-1:0] x_off,
    input  logic [DIM_W-1:0] y_off,
    input  logic [DIM_W-1:0] width,
    input  logic [DIM_W-1:0] height,
    input  logic             halve_h,
    input  logic             halve_v,
    input  logic             drop_frame,
    output logic             frame_start,
    output logic             line_end,
    output logic             keep,
    output logic             clip_err
);

    localparam int EXT_W = DIM_W + 1;

    logic             fv_q, lv_q;
    logic [DIM_W-1:0] x_cnt, y_cnt;
    logic [EXT_W-1:0] x_end, y_end;
    logic             frame_end, px;
    logic             in_x, in_y, keep_x, keep_y;
    logic             odd_x, odd_y;
    logic             short_line, short_frame;

    assign frame_start = in_fv & ~fv_q;
    assign frame_end   = fv_q & ~in_fv;
    assign line_end    = lv_q & ~in_lv;
    assign px          = in_fv & in_lv & in_pv;

    assign x_end = {1'b0, x_off} + {1'b0, width};
    assign y_end = {1'b0, y_off} + {1'b0, height};

    assign in_x = (x_cnt >= x_off) && ({1'b0, x_cnt} < x_end);
    assign in_y = (y_cnt >= y_off) && ({1'b0, y_cnt} < y_end);

    // Parity of the position relative to the window origin.
    assign odd_x = x_cnt[0] ^ x_off[0];
    assign odd_y = y_cnt[0] ^ y_off[0];

    assign keep_x = in_x && !(halve_h && odd_x);
    assign keep_y = in_y && !(halve_v && odd_y);
    assign keep   = px & keep_x & keep_y & ~drop_frame;

    // A window line that ended before reaching the window's right edge,
    // or a frame that ended before reaching its bottom edge.
    assign short_line  = line_end & in_y & ({1'b0, x_cnt} < x_end);
    assign short_frame = frame_end & ({1'b0, y_cnt} < y_end);

    always_ff @(posedge clk) begin
        if (rst) begin
            fv_q     <= 1'b0;
            lv_q     <= 1'b0;
            x_cnt    <= '0;
            y_cnt    <= '0;
            clip_err <= 1'b0;
        end else begin
            fv_q <= in_fv;
            lv_q <= in_lv;
            if (frame_start || line_end) begin
                x_cnt <= '0;
            end else if (px) begin
                x_cnt <= x_cnt + 1'b1;
            end
            if (frame_start) begin
                y_cnt <= '0;
            end else if (line_end) begin
                y_cnt <= y_cnt + 1'b1;
            end
            if (short_line || short_frame) begin
                clip_err <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/cwd_out_stage.sv
module cwd_out_stage
    import cwd_pkg::*;
#(
    parameter int PIX_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             frame_start,
    input  logic             line_end,
    input  logic             keep,
    input  logic [PIX_W-1:0] in_pix,
    output logic             out_valid,
    output logic [PIX_W-1:0] out_pix,
    output mark_t            out_mark,
    output logic             out_lv
);

    // One kept pixel is held back so the last one of a line can be tagged
    // when the line closes, whatever the clipping did to its length.
    logic             hold_v;
    logic [PIX_W-1:0] hold_pix;
    logic             hold_sof;
    logic             sof_due;
    logic             emit, emit_eol;

    assign emit     = hold_v & ((keep & ~frame_start) | (line_end & ~keep));
    assign emit_eol = hold_v & line_end & ~keep;

    always_ff @(posedge clk) begin
        if (rst) begin
            hold_v    <= 1'b0;
            hold_pix  <= '0;
            hold_sof  <= 1'b0;
            sof_due   <= 1'b0;
            out_valid <= 1'b0;
            out_pix   <= '0;
            out_mark  <= '0;
            out_lv    <= 1'b0;
        end else begin
            out_valid <= emit;
            out_mark  <= '0;
            if (emit) begin
                out_pix      <= hold_pix;
                out_mark.sof <= hold_sof;
                out_mark.eol <= emit_eol;
            end
            out_lv <= emit | (out_lv & ~out_mark.eol);

            if (frame_start) begin
                sof_due <= 1'b1;
                hold_v  <= 1'b0;
            end else if (keep) begin
                hold_v   <= 1'b1;
                hold_pix <= in_pix;
                hold_sof <= sof_due;
                sof_due  <= 1'b0;
            end else if (line_end) begin
                hold_v <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/cap_window_decim.sv
module cap_window_decim
    import cwd_pkg::*;
#(
    parameter int DIM_W = 12,
    parameter int PIX_W = 16
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               in_fv,
    input  logic               in_lv,
    input  logic               in_pv,
    input  logic [PIX_W-1:0]   in_pix,
    input  logic [DIM_W-1:0]   cfg_x_off,
    input  logic [DIM_W-1:0]   cfg_y_off,
    input  logic [DIM_W-1:0]   cfg_width,
    input  logic [DIM_W-1:0]   cfg_height,
    input  logic               cfg_halve_h,
    input  logic               cfg_halve_v,
    input  logic [SKIP_W-1:0]  cfg_skip_mask,
    input  logic [SKIP_W-1:0]  cfg_skip_period,
    output logic               out_valid,
    output logic [PIX_W-1:0]   out_pix,
    output logic               out_sof,
    output logic               out_eol,
    output logic               out_lv,
    output logic               clip_err
);

    logic [DIM_W-1:0] sh_x_off, sh_y_off, sh_width, sh_height;
    logic             sh_halve_h, sh_halve_v, sh_drop;
    logic             frame_start, line_end, keep;
    mark_t            mark;

    cwd_cfg_latch #(.DIM_W(DIM_W)) u_cfg (
        .clk             (clk),
        .rst             (rst),
        .frame_start     (frame_start),
        .cfg_x_off       (cfg_x_off),
        .cfg_y_off       (cfg_y_off),
        .cfg_width       (cfg_width),
        .cfg_height      (cfg_height),
        .cfg_halve_h     (cfg_halve_h),
        .cfg_halve_v     (cfg_halve_v),
        .cfg_skip_mask   (cfg_skip_mask),
        .cfg_skip_period (cfg_skip_period),
        .x_off           (sh_x_off),
        .y_off           (sh_y_off),
        .width           (sh_width),
        .height          (sh_height),
        .halve_h         (sh_halve_h),
        .halve_v         (sh_halve_v),
        .drop_frame      (sh_drop)
    );

    cwd_raster #(.DIM_W(DIM_W)) u_raster (
        .clk         (clk),
        .rst         (rst),
        .in_fv       (in_fv),
        .in_lv       (in_lv),
        .in_pv       (in_pv),
        .x_off       (sh_x_off),
        .y_off       (sh_y_off),
        .width       (sh_width),
        .height      (sh_height),
        .halve_h     (sh_halve_h),
        .halve_v     (sh_halve_v),
        .drop_frame  (sh_drop),
        .frame_start (frame_start),
        .line_end    (line_end),
        .keep        (keep),
        .clip_err    (clip_err)
    );

    cwd_out_stage #(.PIX_W(PIX_W)) u_out (
        .clk         (clk),
        .rst         (rst),
        .frame_start (frame_start),
        .line_end    (line_end),
        .keep        (keep),
        .in_pix      (in_pix),
        .out_valid   (out_valid),
        .out_pix     (out_pix),
        .out_mark    (mark),
        .out_lv      (out_lv)
    );

    assign out_sof = mark.sof;
    assign out_eol = mark.eol;

endmodule

// File: rtl/cwd_checker.sv
module cwd_checker (
    input logic clk,
    input logic rst,
    input logic out_valid,
    input logic out_sof,
    input logic out_eol,
    input logic out_lv,
    input logic clip_err
);

    assert_sof_has_pixel_R7: assert property (@(posedge clk) disable iff (rst)
        out_sof |-> out_valid);

    assert_eol_has_pixel_R7: assert property (@(posedge clk) disable iff (rst)
        out_eol |-> out_valid);

    assert_pixel_inside_line_R7: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> out_lv);

    assert_gap_after_eol_R7: assert property (@(posedge clk) disable iff (rst)
        out_eol |=> !out_valid);

    assert_sof_opens_line_R7: assert property (@(posedge clk) disable iff (rst)
        out_sof |-> !($past(out_lv) && !$past(out_eol)));

    assert_clip_sticky_R8: assert property (@(posedge clk) disable iff (rst)
        clip_err |=> clip_err);

    assert_quiet_after_reset_R9: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> !out_valid && !out_lv && !clip_err);

endmodule

bind cap_window_decim cwd_checker u_chk (
    .clk       (clk),
    .rst       (rst),
    .out_valid (out_valid),
    .out_sof   (out_sof),
    .out_eol   (out_eol),
    .out_lv    (out_lv),
    .clip_err  (clip_err)
);

// File: tb/sim_cap_window_decim.sv
module sim_cap_window_decim;
    import cwd_pkg::*;

    localparam int DIM_W = 12;
    localparam int PIX_W = 16;
    localparam int MAXP  = 4096;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #4 clk = ~clk;

    logic              in_fv = 0, in_lv = 0, in_pv = 0;
    logic [PIX_W-1:0]  in_pix = '0;
    logic [DIM_W-1:0]  cfg_x_off = '0, cfg_y_off = '0, cfg_width = '0, cfg_height = '0;
    logic              cfg_halve_h = 0, cfg_halve_v = 0;
    logic [SKIP_W-1:0] cfg_skip_mask = '0, cfg_skip_period = '0;
    logic              out_valid, out_sof, out_eol, out_lv, clip_err;
    logic [PIX_W-1:0]  out_pix;

    cap_window_decim #(.DIM_W(DIM_W), .PIX_W(PIX_W)) u0 (
        .clk(clk), .rst(rst), .in_fv(in_fv), .in_lv(in_lv), .in_pv(in_pv),
        .in_pix(in_pix), .cfg_x_off(cfg_x_off), .cfg_y_off(cfg_y_off),
        .cfg_width(cfg_width), .cfg_height(cfg_height),
        .cfg_halve_h(cfg_halve_h), .cfg_halve_v(cfg_halve_v),
        .cfg_skip_mask(cfg_skip_mask), .cfg_skip_period(cfg_skip_period),
        .out_valid(out_valid), .out_pix(out_pix), .out_sof(out_sof),
        .out_eol(out_eol), .out_lv(out_lv), .clip_err(clip_err)
    );

    int checks = 0;
    int failures = 0;
    bit finished = 0;

    logic [PIX_W-1:0] got_pix [MAXP];
    bit               got_sof [MAXP];
    bit               got_eol [MAXP];
    int               got_n;
    logic [PIX_W-1:0] exp_pix [MAXP];
    bit               exp_sof [MAXP];
    bit               exp_eol [MAXP];
    int               exp_n;
    int               lv_rises, lv_bad;
    logic             lv_prev = 0;

    // Pending mid-frame settings for the R6 scenario.
    int nx_xo, nx_yo, nx_w, nx_h;
    bit nx_hh, nx_hv;

    always @(negedge clk) begin
        if (rst) begin
            lv_prev = 1'b0;
        end else begin
            if (out_valid) begin
                if (got_n < MAXP) begin
                    got_pix[got_n] = out_pix;
                    got_sof[got_n] = out_sof;
                    got_eol[got_n] = out_eol;
                end
                got_n++;
                if (!out_lv) lv_bad++;
            end
            if (out_lv && !lv_prev) lv_rises++;
            lv_prev = out_lv;
        end
    end

    task automatic check(bit ok, string req, string what, int act, int expv);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, expv);
        end
    endtask

    task automatic set_cfg(int xo, int yo, int w, int h, bit hh, bit hv, int mask, int period);
        cfg_x_off       = DIM_W'(xo);
        cfg_y_off       = DIM_W'(yo);
        cfg_width       = DIM_W'(w);
        cfg_height      = DIM_W'(h);
        cfg_halve_h     = hh;
        cfg_halve_v     = hv;
        cfg_skip_mask   = SKIP_W'(mask);
        cfg_skip_period = SKIP_W'(period);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        in_fv = 0; in_lv = 0; in_pv = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        got_n = 0; exp_n = 0; lv_rises = 0; lv_bad = 0;
        @(negedge clk);
    endtask

    // One input frame; pixel data is {row, column}. With gaps, every third
    // cycle of a line has pixel-valid low. chg_line applies the nx_* settings.
    task automatic send_frame(int iw, int ih, bit gaps, int chg_line);
        int cyc = 0;
        in_fv = 1'b1;
        repeat (2) @(negedge clk);
        for (int y = 0; y < ih; y++) begin
            int x = 0;
            if (y == chg_line)
                set_cfg(nx_xo, nx_yo, nx_w, nx_h, nx_hh, nx_hv, 0, 0);
            while (x < iw) begin
                in_lv  = 1'b1;
                in_pv  = !(gaps && (cyc % 3 == 2));
                in_pix = {8'(y), 8'(x)};
                cyc++;
                @(negedge clk);
                if (in_pv) x++;
            end
            in_lv = 1'b0;
            in_pv = 1'b0;
            repeat (3) @(negedge clk);
        end
        repeat (2) @(negedge clk);
        in_fv = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    task automatic model_frame(int iw, int ih, int xo, int yo, int w, int h, bit hh, bit hv);
        bit first = 1;
        for (int y = 0; y < ih; y++) begin
            int last = -1;
            if (y < yo || y >= yo + h) continue;
            if (hv && ((y - yo) % 2 != 0)) continue;
            for (int x = 0; x < iw; x++) begin
                if (x < xo || x >= xo + w) continue;
                if (hh && ((x - xo) % 2 != 0)) continue;
                exp_pix[exp_n] = {8'(y), 8'(x)};
                exp_sof[exp_n] = first;
                exp_eol[exp_n] = 1'b0;
                first = 0;
                last = exp_n;
                exp_n++;
            end
            if (last >= 0) exp_eol[last] = 1'b1;
        end
    endtask

    task automatic compare(string req);
        int mism = 0;
        check(got_n == exp_n, req, "pixel count", got_n, exp_n);
        for (int i = 0; i < exp_n && i < got_n; i++) begin
            if (got_pix[i] !== exp_pix[i] || got_sof[i] != exp_sof[i] || got_eol[i] != exp_eol[i]) begin
                if (mism == 0)
                    $display("  first difference at %0d: pix %h/%h sof %0d/%0d eol %0d/%0d",
                             i, got_pix[i], exp_pix[i], got_sof[i], exp_sof[i], got_eol[i], exp_eol[i]);
                mism++;
            end
        end
        check(mism == 0, req, "pixel/marker mismatches", mism, 0);
    endtask

    function automatic int count_eol();
        int c = 0;
        for (int i = 0; i < got_n && i < MAXP; i++) if (got_eol[i]) c++;
        return c;
    endfunction

    function automatic int count_sof();
        int c = 0;
        for (int i = 0; i < got_n && i < MAXP; i++) if (got_sof[i]) c++;
        return c;
    endfunction

    task automatic t_reset();
        @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        check(!out_valid && !out_sof && !out_eol, "R9", "markers during reset", 32'(out_valid), 0);
        check(!out_lv && !clip_err, "R9", "lv/err during reset", 32'(clip_err), 0);
        rst = 1'b0;
        @(negedge clk);
        check(!out_valid && !out_lv && !clip_err, "R9", "state after reset", 32'(out_valid), 0);
    endtask

    task automatic t_crop();
        set_cfg(3, 2, 8, 5, 0, 0, 0, 0);
        do_reset();
        send_frame(20, 12, 0, -1);
        model_frame(20, 12, 3, 2, 8, 5, 0, 0);
        compare("R1");
        check(count_eol() == 5, "R4", "rows when not halved", count_eol(), 5);
        check(clip_err == 1'b0, "R8", "no clip for inner window", 32'(clip_err), 0);
    endtask

    task automatic t_halve_h();
        set_cfg(3, 1, 9, 4, 1, 0, 0, 0);
        do_reset();
        send_frame(20, 12, 0, -1);
        model_frame(20, 12, 3, 1, 9, 4, 1, 0);
        compare("R2");
        check(got_n == 20, "R2", "5 columns x 4 rows", got_n, 20);
    endtask

    task automatic t_halve_v();
        set_cfg(2, 3, 6, 7, 0, 1, 0, 0);
        do_reset();
        send_frame(20, 12, 0, -1);
        model_frame(20, 12, 2, 3, 6, 7, 0, 1);
        compare("R3");
        check(count_eol() == 4, "R3", "rows kept of 7", count_eol(), 4);
    endtask

    task automatic t_both();
        set_cfg(8, 4, 32, 24, 1, 1, 0, 0);
        do_reset();
        send_frame(64, 48, 1, -1);
        model_frame(64, 48, 8, 4, 32, 24, 1, 1);
        compare("R4");
        check(got_n == 192, "R4", "16x12 pixel total", got_n, 192);
        check(count_eol() == 12, "R4", "output rows", count_eol(), 12);
        check(lv_rises == 12, "R7", "out_lv line pulses", lv_rises, 12);
        check(lv_bad == 0, "R7", "valid outside out_lv", lv_bad, 0);
        check(count_sof() == 1, "R7", "sof count", count_sof(), 1);
    endtask

    task automatic t_skip();
        set_cfg(0, 0, 8, 4, 0, 0, 5'b00001, 2);
        do_reset();
        for (int f = 0; f < 4; f++) begin
            send_frame(8, 4, 0, -1);
            if (f % 2 == 1) model_frame(8, 4, 0, 0, 8, 4, 0, 0);
        end
        compare("R5");
        check(count_sof() == 2, "R5", "half-rate frames passed of 4", count_sof(), 2);

        set_cfg(0, 0, 8, 4, 0, 0, 5'b00101, 3);
        do_reset();
        for (int f = 0; f < 6; f++) begin
            send_frame(8, 4, 0, -1);
            if (f % 3 == 1) model_frame(8, 4, 0, 0, 8, 4, 0, 0);
        end
        compare("R5");
        check(count_sof() == 2, "R5", "period-3 frames passed of 6", count_sof(), 2);
    endtask

    task automatic t_cfg_change();
        set_cfg(1, 1, 6, 4, 0, 0, 0, 0);
        do_reset();
        nx_xo = 4; nx_yo = 0; nx_w = 5; nx_h = 6; nx_hh = 1; nx_hv = 1;
        send_frame(12, 8, 0, 2);
        model_frame(12, 8, 1, 1, 6, 4, 0, 0);
        send_frame(12, 8, 0, -1);
        model_frame(12, 8, 4, 0, 5, 6, 1, 1);
        compare("R6");
    endtask

    task automatic t_clip();
        set_cfg(6, 3, 8, 5, 0, 0, 0, 0);
        do_reset();
        send_frame(10, 6, 0, -1);
        model_frame(10, 6, 6, 3, 8, 5, 0, 0);
        compare("R8");
        check(clip_err == 1'b1, "R8", "clip flag raised", 32'(clip_err), 1);
        set_cfg(0, 0, 4, 2, 0, 0, 0, 0);
        send_frame(10, 6, 0, -1);
        check(clip_err == 1'b1, "R8", "clip flag sticky", 32'(clip_err), 1);
    endtask

    initial begin
        t_reset();
        t_crop();
        t_halve_h();
        t_halve_v();
        t_both();
        t_skip();
        t_cfg_change();
        t_clip();
        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(8 * 200000);
        if (!finished) begin
            checks++;
            failures++;
            $display("FAIL watchdog run did not complete actual=0 expected=1");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule